// File: doc/BRIEF.md
# Noise-Shaped Fractional Clock Divider

This block takes a resonator clock of roughly 524 kHz and divides it down to a 32.768 kHz clock whose long-run frequency is set by a fractional control word. The word has an integer part near 16 and a binary fraction. A second-order delta-sigma modulator picks an integer divide value for every output period. The modulator is built from two cascaded accumulators. The average ratio therefore equals the programmed fractional value, and the quantisation error is pushed to high frequencies. The control word is supplied already trimmed, so that the average output frequency cancels the resonator's ppm error. The default 20-bit fraction gives a step of about 0.06 ppm at a ratio of 16, which covers a correction range far wider than ±100 ppm.

Each output period is an exact number of reference cycles. The output is high for the first half of the period, rounded down. A new divide value is taken up only where one period ends and the next begins, so no period is ever cut short or stretched part way through. When the low-power mode is selected, the divided clock is used directly, without a downstream PLL. The block also counts whole output periods to form a slow square wave: one cycle per 32768 periods, which is 1 Hz at the nominal rate.

Top module: `frac_clk_divider`

## Requirements
- R1: While rst_n is low, both outputs are 0, and both accumulators and the delayed carry are cleared. After reset, the first rising reference edge with enable high starts a period, so clk_div_o is 1 after that edge.
- R2: An output period of N reference cycles has clk_div_o high for the first floor(N/2) cycles and low for the rest. N equals the effective integer part plus a correction in the range −1 to +2.
- R3: With div_frac equal to 0, every period lasts exactly the effective integer part.
- R4: From reset, the first 2^(FRAC_W+1) periods add up to exactly 2^(FRAC_W+1)·I + 2·F reference cycles, where I is the integer part and F is the fraction.
- R5: At each period start, the fraction is added to accumulator A, giving carry c1. The new A is then added to accumulator B, giving carry c2. Both sums are taken modulo 2^FRAC_W. The correction is c1 + c2 − (c2 of the previous period start), and the stored previous carry is then replaced by c2.
- R6: A change to div_int or div_frac made during a period does not alter that period. It applies from the next period start.
- R7: While enable is low, clk_div_o is 0 from the next edge on and the accumulators hold their values. The first edge with enable high again starts a new period, and the correction sequence continues where it stopped.
- R8: A div_int value below 3 is treated as 3.
- R9: With lp_mode high, clk_1hz_o changes only at period starts. Counting from the first period start after lp_mode rises, it is high for SEC_COUNT/2 periods, then low for SEC_COUNT/2 periods, and then repeats.
- R10: While lp_mode is low, clk_1hz_o is 0 from the next edge on, and the period count is cleared, so that a later entry to low-power mode restarts the pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Resonator reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the divider; low holds it idle |
| lp_mode | input | 1 | Low-power mode: drive the slow output |
| div_int | input | INT_W | Integer part of the divide ratio |
| div_frac | input | FRAC_W | Fraction of the divide ratio, in units of 2^-FRAC_W |
| clk_div_o | output | 1 | Divided clock, about 32.768 kHz |
| clk_1hz_o | output | 1 | Slow square wave in low-power mode |

## Verification
The bench uses a narrow fraction, so that complete modulator cycles fit in a short run, and a short seconds count. A zero fraction must give periods of constant length, which separates the plain counter from the modulator. Several nonzero fractions, one small, one near full scale with a lower integer part, and one odd, are followed period by period against an independent model of the accumulator recurrence. This exposes errors in the carry order or the delayed-carry term that a mean value would hide. A long run over a whole modulator cycle checks the exact total. Mid-period word changes, enable drops, integer values below the limit, and entries to and exits from the low-power mode each test one boundary rule.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // Lowest integer divide value the counter accepts.
  localparam int unsigned MIN_DIV = 3;

  // Combine the two stage carries and the delayed second carry into a
  // signed correction in the range -1..+2.
  function automatic logic signed [2:0] mash_combine(input logic c1,
                                                     input logic c2,
                                                     input logic c2_prev);
    return $signed({2'b00, c1}) + $signed({2'b00, c2}) - $signed({2'b00, c2_prev});
  endfunction

  // Output level for a count-down value 'left' inside a period of 'len'.
  function automatic logic in_high_phase(input int unsigned left,
                                         input int unsigned len);
    int unsigned pos;
    pos = len - 1 - left;
    return pos < (len >> 1);
  endfunction

  // Lift a value to a lower limit.
  function automatic int unsigned floor_to(input int unsigned v,
                                           input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/fdiv_mash2.sv
module fdiv_mash2 import fdiv_pkg::*; #(
  parameter int FRAC_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [FRAC_W-1:0]   frac,
  output logic signed [2:0]   adj
);

  logic [FRAC_W-1:0] acc_a, acc_b;
  logic              carry2_d;
  logic [FRAC_W:0]   sum_a, sum_b;
  logic              carry1, carry2;

  always_comb begin
    sum_a  = {1'b0, acc_a} + {1'b0, frac};
    carry1 = sum_a[FRAC_W];
    sum_b  = {1'b0, acc_b} + {1'b0, sum_a[FRAC_W-1:0]};
    carry2 = sum_b[FRAC_W];
    adj    = mash_combine(carry1, carry2, carry2_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a    <= '0;
      acc_b    <= '0;
      carry2_d <= 1'b0;
    end else if (step) begin
      acc_a    <= sum_a[FRAC_W-1:0];
      acc_b    <= sum_b[FRAC_W-1:0];
      carry2_d <= carry2;
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(acc_a) && $stable(acc_b) && $stable(carry2_d))); // R7

endmodule

// File: rtl/fdiv_period_ctr.sv
module fdiv_period_ctr import fdiv_pkg::*; #(
  parameter int NW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [NW-1:0] n_load,
  output logic          boundary,
  output logic [NW-1:0] cur_n,
  output logic          clk_o
);

  logic [NW-1:0] left_q, left_d, n_d;
  logic          clk_d;

  assign boundary = enable && (left_q == '0);

  always_comb begin
    if (!enable) begin
      left_d = '0;
      n_d    = cur_n;
      clk_d  = 1'b0;
    end else if (boundary) begin
      left_d = n_load - NW'(1);
      n_d    = n_load;
      clk_d  = in_high_phase(32'(left_d), 32'(n_d));
    end else begin
      left_d = left_q - NW'(1);
      n_d    = cur_n;
      clk_d  = in_high_phase(32'(left_d), 32'(n_d));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      cur_n  <= '0;
      clk_o  <= 1'b0;
    end else begin
      left_q <= left_d;
      cur_n  <= n_d;
      clk_o  <= clk_d;
    end
  end

  AST_LOAD_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(cur_n)); // R6
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> clk_o); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !clk_o); // R7
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0) || (left_q < cur_n)); // R2

endmodule

// File: rtl/fdiv_sec_ctr.sv
module fdiv_sec_ctr #(
  parameter int SEC_COUNT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_mode,
  input  logic tick,
  output logic slow_o
);

  localparam int SW   = (SEC_COUNT > 2) ? $clog2(SEC_COUNT) : 1;
  localparam int HALF = SEC_COUNT / 2;

  logic [SW-1:0] idx_q;
  logic          wrap;

  assign wrap = (idx_q == SW'(SEC_COUNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      slow_o <= 1'b0;
    end else if (!lp_mode) begin
      idx_q  <= '0;
      slow_o <= 1'b0;
    end else if (tick) begin
      slow_o <= (idx_q < SW'(HALF));
      idx_q  <= wrap ? '0 : idx_q + SW'(1);
    end
  end

  AST_SLOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_mode |=> !slow_o); // R10
  AST_SLOW_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && !tick) |=> $stable(slow_o)); // R9

endmodule

// File: rtl/frac_clk_divider.sv
module frac_clk_divider import fdiv_pkg::*; #(
  parameter int FRAC_W    = 20,
  parameter int INT_W     = 6,
  parameter int SEC_COUNT = 32768
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              lp_mode,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              clk_div_o,
  output logic              clk_1hz_o
);

  localparam int NW = INT_W + 1;

  logic [INT_W-1:0]   int_eff;
  logic signed [2:0]  adj;
  logic signed [NW:0] n_sum;
  logic [NW-1:0]      n_load;
  logic [NW-1:0]      cur_n;
  logic               boundary;

  assign int_eff = INT_W'(floor_to(32'(div_int), MIN_DIV));
  assign n_sum   = $signed({2'b00, int_eff}) + adj;
  assign n_load  = n_sum[NW-1:0];

  fdiv_mash2 #(.FRAC_W(FRAC_W)) u_mash (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .step  (boundary),
    .frac  (div_frac),
    .adj   (adj)
  );

  fdiv_period_ctr #(.NW(NW)) u_ctr (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .enable   (enable),
    .n_load   (n_load),
    .boundary (boundary),
    .cur_n    (cur_n),
    .clk_o    (clk_div_o)
  );

  fdiv_sec_ctr #(.SEC_COUNT(SEC_COUNT)) u_sec (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .lp_mode(lp_mode),
    .tick   (boundary),
    .slow_o (clk_1hz_o)
  );

  AST_ADJ_RANGE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    boundary |=> ((int'(cur_n) >= int'($past(int_eff)) - 1) &&
                  (int'(cur_n) <= int'($past(int_eff)) + 2))); // R2
  AST_MIN_DIV: assert property (@(posedge clk_ref) disable iff (!rst_n)
    boundary |=> (int'(cur_n) >= int'(MIN_DIV) - 1)); // R8

endmodule

// File: tb/test_frac_clk_divider.sv
module test_frac_clk_divider;

  localparam int FW  = 8;
  localparam int IW  = 6;
  localparam int SEC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          lp_mode = 1'b0;
  logic [IW-1:0] div_int = '0;
  logic [FW-1:0] div_frac = '0;
  logic          clk_div_o, clk_1hz_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model state
  int m_a, m_b, m_c2p;

  always #10 clk = ~clk;

  frac_clk_divider #(.FRAC_W(FW), .INT_W(IW), .SEC_COUNT(SEC)) i_frac_clk_divider (
    .clk_ref  (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .lp_mode  (lp_mode),
    .div_int  (div_int),
    .div_frac (div_frac),
    .clk_div_o(clk_div_o),
    .clk_1hz_o(clk_1hz_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected length of the next period from the stated recurrence.
  function automatic int model_len(input int i, input int f);
    int full, c1, c2, y, ie;
    full  = 1 << FW;
    m_a   = m_a + f;
    c1    = m_a / full;
    m_a   = m_a % full;
    m_b   = m_b + m_a;
    c2    = m_b / full;
    m_b   = m_b % full;
    y     = c1 + c2 - m_c2p;
    m_c2p = c2;
    ie    = (i < 3) ? 3 : i;
    return ie + y;
  endfunction

  task automatic do_reset(input int i, input int f);
    rst_n = 1'b0; enable = 1'b0; lp_mode = 1'b0;
    div_int = IW'(i); div_frac = FW'(f);
    m_a = 0; m_b = 0; m_c2p = 0;
    repeat (3) @(negedge clk);
    chk(clk_div_o == 1'b0, "R1", "clk_div in reset", clk_div_o, 0);
    chk(clk_1hz_o == 1'b0, "R1", "clk_1hz in reset", clk_1hz_o, 0);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
  endtask

  // Called at the negedge just after a rise; returns at the next such point.
  task automatic measure(output int len, output int hi);
    logic p;
    len = 1; hi = 1; p = 1'b1;
    forever begin
      @(negedge clk);
      if (clk_div_o && !p) break;
      len++;
      if (clk_div_o) hi++;
      p = clk_div_o;
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = clk_div_o;
    forever begin
      @(negedge clk);
      if (clk_div_o && !p) break;
      p = clk_div_o;
    end
  endtask

  task automatic run_model(input int k, input string req);
    int len, hi, e;
    for (int n = 0; n < k; n++) begin
      e = model_len(int'(div_int), int'(div_frac));
      measure(len, hi);
      chk(len == e, req, "period length", len, e);
      chk(hi == e / 2, "R2", "high cycles", hi, e / 2);
    end
  endtask

  task automatic t_reset_start();
    do_reset(16, 0);
    chk(clk_div_o == 1'b1, "R1", "first edge starts period", clk_div_o, 1);
    run_model(1, "R1");
  endtask

  task automatic t_integer();
    int len, hi;
    do_reset(16, 0);
    for (int n = 0; n < 4; n++) begin
      measure(len, hi);
      chk(len == 16, "R3", "zero fraction length", len, 16);
      chk(hi == 8, "R2", "zero fraction high", hi, 8);
    end
    div_int = IW'(13);
    measure(len, hi);
    chk(len == 16, "R6", "period in progress", len, 16);
    for (int n = 0; n < 3; n++) begin
      measure(len, hi);
      chk(len == 13, "R3", "odd length", len, 13);
      chk(hi == 6, "R2", "odd high rounded down", hi, 6);
    end
  endtask

  task automatic t_sequence(input int i, input int f);
    do_reset(i, f);
    run_model(40, "R5");
  endtask

  task automatic t_word_change();
    int len, hi, e;
    do_reset(16, 'h35);
    run_model(5, "R5");
    e = model_len(16, 'h35);
    div_int = IW'(20); div_frac = FW'('hC1);
    measure(len, hi);
    chk(len == e, "R6", "old word kept mid-period", len, e);
    run_model(10, "R6");
  endtask

  task automatic t_average();
    int len, hi, sum, e, k;
    k = 1 << (FW + 1);
    do_reset(16, 'h9D);
    sum = 0;
    for (int n = 0; n < k; n++) begin
      measure(len, hi);
      sum += len;
    end
    e = k * 16 + 2 * 'h9D;
    chk(sum == e, "R4", "total over full modulator cycle", sum, e);
  endtask

  task automatic t_enable();
    int len, hi, e;
    do_reset(16, 'h35);
    run_model(6, "R5");
    e = model_len(16, 'h35);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      chk(clk_div_o == 1'b0, "R7", "output low while disabled", clk_div_o, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    chk(clk_div_o == 1'b1, "R7", "restart on enable", clk_div_o, 1);
    run_model(12, "R7");
  endtask

  task automatic t_clamp();
    int len, hi;
    do_reset(1, 0);
    for (int n = 0; n < 3; n++) begin
      measure(len, hi);
      chk(len == 3, "R8", "clamped length", len, 3);
      chk(hi == 1, "R8", "clamped high", hi, 1);
    end
    div_int = '0;
    measure(len, hi);
    for (int n = 0; n < 2; n++) begin
      measure(len, hi);
      chk(len == 3, "R8", "zero clamped length", len, 3);
    end
  endtask

  task automatic t_low_power();
    int len, hi, exp1;
    do_reset(16, 0);
    wait_rise();
    lp_mode = 1'b1;
    chk(clk_1hz_o == 1'b0, "R9", "slow low before first start", clk_1hz_o, 0);
    measure(len, hi);
    for (int n = 0; n < 2 * SEC; n++) begin
      exp1 = ((n % SEC) < SEC / 2) ? 1 : 0;
      chk(clk_1hz_o == exp1[0], "R9", "slow level at period start", clk_1hz_o, exp1);
      measure(len, hi);
    end
    // now at index 0 of a frame, slow output high
    chk(clk_1hz_o == 1'b1, "R9", "frame restart high", clk_1hz_o, 1);
    measure(len, hi);
    lp_mode = 1'b0;
    @(negedge clk);
    chk(clk_1hz_o == 1'b0, "R10", "slow cleared on exit", clk_1hz_o, 0);
    wait_rise();
    chk(clk_1hz_o == 1'b0, "R10", "slow stays low out of mode", clk_1hz_o, 0);
    lp_mode = 1'b1;
    measure(len, hi);
    chk(clk_1hz_o == 1'b1, "R10", "pattern restarts at index 0", clk_1hz_o, 1);
    for (int n = 1; n < SEC; n++) begin
      measure(len, hi);
      exp1 = (n < SEC / 2) ? 1 : 0;
      chk(clk_1hz_o == exp1[0], "R10", "restarted frame", clk_1hz_o, exp1);
    end
  endtask

  initial begin
    t_reset_start();
    t_integer();
    t_sequence(16, 'h35);
    t_sequence(15, 'hF3);
    t_sequence(16, 'h01);
    t_word_change();
    t_average();
    t_enable();
    t_clamp();
    t_low_power();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule